// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Controller

This block keeps the replacement history for a set-associative cache with `NUM_SETS` sets and `NUM_WAYS` ways. Each set's history is a binary tree of `NUM_WAYS-1` bits. All of these trees sit in one small RAM, indexed by set. The RAM is read without a clock, and a single copy of combinational logic serves every set. That logic turns a tree into a victim way, and it turns a tree plus a touched way into the updated tree.

The cache reports each finished tag lookup with a strobe, the set, a hit flag and the hit way. The block handles that report in the next cycle.
- **Hit:** the set's tree is rewritten so the hit way becomes most recently used.
- **Miss:** a victim way is chosen from the tree that was read. The victim is placed in a holding register, and the tree is updated to mark the victim as used. A second miss to the same set therefore picks a different way.
- **Holding the victim:** it stays on the outputs with a valid flag until the miss handler acknowledges it, however long that takes.

After reset, a sweep writes zeros into every RAM entry, one set per cycle. The block raises `ready` when the sweep is complete.

Top module: `plru_ctrl`

## Requirements
- R1: After reset, `ready` is low for exactly `NUM_SETS` cycles, then rises and stays high. `victim_valid` is low whenever `ready` is low.
- R2: A lookup strobe presented while `ready` is low is ignored. It captures no victim and leaves that set's tree unchanged.
- R3: Tree encoding:
  - Each node bit equal to 0 points toward the lower-numbered half of its subtree as the less recently used side.
  - After initialisation, every tree is all zeros, so the first miss in a set picks way 0.
- R4: Every miss that captures a victim also marks that victim as used. With four ways, repeated misses to one set, each acknowledged before the next, pick ways 0, 2, 1, 3 and then 0 again.
- R5: A hit marks the hit way most recently used. With four ways, a hit on way 0 in a fresh set followed by a miss picks way 2.
- R6: While `victim_valid` is high and `victim_ack` is low, the valid flag and `victim_way` hold their values. Hits to any set in the meantime do not change them.
- R7: In the handling cycle, if there is no new miss capture, `victim_ack` clears `victim_valid` on the next edge. An acknowledge while no victim is held has no effect.
- R8: A miss handled while a victim is held and not acknowledged is dropped. The held victim is kept, and the tree of the missing set is not updated.
- R9: A miss handled in the same cycle as `victim_ack` captures its new victim, and `victim_valid` stays high.
- R10: Lookups to one set never change the victim chosen for another set.
- R11: Lookups to the same set in consecutive cycles each see the tree written by the one before. The result matches handling them one at a time.
- R12: Over any mix of hits, misses and acknowledges, the captured victim way equals that of a tree pseudo-LRU model that follows R3 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | A tag lookup finished this cycle |
| lookup_set | input | $clog2(NUM_SETS) | Set index of the lookup |
| lookup_hit | input | 1 | 1 = hit, 0 = miss |
| lookup_way | input | $clog2(NUM_WAYS) | Way that hit (ignored on a miss) |
| victim_ack | input | 1 | Miss handler takes the held victim |
| ready | output | 1 | Initialisation sweep finished |
| victim_valid | output | 1 | A victim way is held |
| victim_way | output | $clog2(NUM_WAYS) | Held victim way index |

## Verification
The bench builds the block with four sets and four ways. This keeps the initialisation sweep short. It also makes the whole replacement order of a set (0, 2, 1, 3) visible within a handful of misses. With only four sets, a pseudo-random run of a few hundred operations keeps running into the following cases:
- consecutive same-set accesses;
- misses that are dropped while a victim is pending;
- acknowledges that coincide with a new capture.

Each of these is compared against an independent tree model in the bench.

// File: rtl/plru_pkg.sv
package plru_pkg;

    // Controller phase: sweeping the state RAM to zero, or serving lookups.
    typedef enum logic {
        PH_INIT = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Index width helper that never returns zero.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/plru_tree_fn.sv
// Single shared combinational tree function: decodes the victim way of a tree
// and produces the tree after a given way is touched.
module plru_tree_fn #(
    parameter  int NUM_WAYS = 8,
    localparam int WB       = plru_pkg::idx_bits(NUM_WAYS)
) (
    input  logic [NUM_WAYS-2:0] state_i,
    input  logic [WB-1:0]       touch_i,
    output logic [WB-1:0]       victim_o,
    output logic [NUM_WAYS-2:0] next_o
);

    // Tree padded to a power-of-two width so that a WB-bit node index fits exactly.
    logic [NUM_WAYS-1:0] st_pad;
    assign st_pad = {1'b0, state_i};

    // Victim walk: from the root, follow each node bit toward the older half.
    always_comb begin
        logic [WB:0] node;
        node = (WB+1)'(1);
        for (int lvl = 0; lvl < WB; lvl++) begin
            node = {node[WB-1:0], st_pad[WB'(node - 1'b1)]};
        end
        victim_o = node[WB-1:0];
    end

    // Update walk: along the path of the touched way, point each node away from it.
    always_comb begin
        logic [WB:0]         node;
        logic [NUM_WAYS-1:0] nxt;
        logic                dir;
        node = (WB+1)'(1);
        nxt  = st_pad;
        for (int lvl = 0; lvl < WB; lvl++) begin
            dir = touch_i[WB-1-lvl];
            nxt[WB'(node - 1'b1)] = ~dir;
            node = {node[WB-1:0], dir};
        end
        next_o = nxt[NUM_WAYS-2:0];
    end

endmodule

// File: rtl/plru_state_ram.sv
// Small state store: asynchronous read, synchronous write, no reset.
module plru_state_ram #(
    parameter  int DEPTH = 64,
    parameter  int WIDTH = 7,
    localparam int AW    = plru_pkg::idx_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/plru_victim_hold.sv
// Holds a captured victim way until the miss handler acknowledges it.
module plru_victim_hold #(
    parameter int WB = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [WB-1:0] capture_way,
    input  logic          ack,
    output logic          held_valid,
    output logic [WB-1:0] held_way
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_way   <= '0;
        end else if (capture) begin
            held_valid <= 1'b1;
            held_way   <= capture_way;
        end else if (ack) begin
            held_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/plru_ctrl.sv
// Pseudo-LRU replacement controller: per-set trees in a small RAM,
// one shared decode/update function, victim held for deferred miss handling.
module plru_ctrl #(
    parameter  int NUM_SETS = 64,
    parameter  int NUM_WAYS = 8,
    localparam int SET_BITS = plru_pkg::idx_bits(NUM_SETS),
    localparam int WAY_BITS = plru_pkg::idx_bits(NUM_WAYS),
    localparam int TREE_W   = NUM_WAYS - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lookup_valid,
    input  logic [SET_BITS-1:0] lookup_set,
    input  logic                lookup_hit,
    input  logic [WAY_BITS-1:0] lookup_way,
    input  logic                victim_ack,
    output logic                ready,
    output logic                victim_valid,
    output logic [WAY_BITS-1:0] victim_way
);
    import plru_pkg::*;

    // Lookup report registered into the handling cycle.
    typedef struct packed {
        logic                vld;
        logic                hit;
        logic [WAY_BITS-1:0] way;
        logic [SET_BITS-1:0] set;
    } stage_t;

    phase_e              phase;
    logic [SET_BITS-1:0] init_idx;
    stage_t              stg;

    logic [TREE_W-1:0]   rd_tree;
    logic [TREE_W-1:0]   nxt_tree;
    logic [WAY_BITS-1:0] fn_victim;
    logic [WAY_BITS-1:0] touch_way;
    logic                miss_take;
    logic                ram_we;
    logic [SET_BITS-1:0] ram_waddr;
    logic [TREE_W-1:0]   ram_wdata;

    // Initialisation sweep: one RAM entry per cycle, then serve lookups.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_INIT;
            init_idx <= '0;
        end else if (phase == PH_INIT) begin
            if (init_idx == SET_BITS'(NUM_SETS - 1)) begin
                phase <= PH_RUN;
            end
            init_idx <= init_idx + 1'b1;
        end
    end

    assign ready = (phase == PH_RUN);

    // Handling stage: lookups are accepted only once the sweep is done.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg.vld <= lookup_valid & ready;
            stg.hit <= lookup_hit;
            stg.way <= lookup_way;
            stg.set <= lookup_set;
        end
    end

    plru_state_ram #(
        .DEPTH (NUM_SETS),
        .WIDTH (TREE_W)
    ) ram_i (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (stg.set),
        .rdata (rd_tree)
    );

    plru_tree_fn #(
        .NUM_WAYS (NUM_WAYS)
    ) fn_i (
        .state_i  (rd_tree),
        .touch_i  (touch_way),
        .victim_o (fn_victim),
        .next_o   (nxt_tree)
    );

    // A miss is taken only if the holding register is free or released now.
    assign miss_take = stg.vld & ~stg.hit & (~victim_valid | victim_ack);
    assign touch_way = stg.hit ? stg.way : fn_victim;

    always_comb begin
        if (phase == PH_INIT) begin
            ram_we    = 1'b1;
            ram_waddr = init_idx;
            ram_wdata = '0;
        end else begin
            ram_we    = stg.vld & (stg.hit | miss_take);
            ram_waddr = stg.set;
            ram_wdata = nxt_tree;
        end
    end

    plru_victim_hold #(
        .WB (WAY_BITS)
    ) hold_i (
        .clk         (clk),
        .rst         (rst),
        .capture     (miss_take),
        .capture_way (fn_victim),
        .ack         (victim_ack),
        .held_valid  (victim_valid),
        .held_way    (victim_way)
    );

endmodule

// File: rtl/plru_ctrl_checker.sv
module plru_ctrl_checker #(
    parameter int WB = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          victim_valid,
    input logic [WB-1:0] victim_way,
    input logic          victim_ack,
    input logic          miss_take
);

    a_r1_no_victim_before_ready: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !victim_valid);

    a_r1_ready_sticks: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    a_r2_no_capture_before_ready: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !miss_take);

    a_r6_victim_held: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && !victim_ack) |=> (victim_valid && $stable(victim_way)));

    a_r7_ack_releases: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && victim_ack && !miss_take) |=> !victim_valid);

    a_r9_capture_sets_valid: assert property (@(posedge clk) disable iff (rst)
        miss_take |=> victim_valid);

endmodule

bind plru_ctrl plru_ctrl_checker #(.WB(WAY_BITS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ready        (ready),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .victim_ack   (victim_ack),
    .miss_take    (miss_take)
);

// File: tb/plru_ctrl_tb.sv
module plru_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int W  = 4;
    localparam int SB = 2;
    localparam int WB = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lookup_valid = 1'b0;
    logic [SB-1:0] lookup_set = '0;
    logic          lookup_hit = 1'b0;
    logic [WB-1:0] lookup_way = '0;
    logic          victim_ack = 1'b0;
    logic          ready;
    logic          victim_valid;
    logic [WB-1:0] victim_way;

    int checks = 0;
    int failures = 0;

    // Reference model state.
    logic [W-2:0] mdl [N];
    bit           held_v = 1'b0;
    int           held_w = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plru_ctrl #(.NUM_SETS(N), .NUM_WAYS(W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .lookup_valid (lookup_valid),
        .lookup_set   (lookup_set),
        .lookup_hit   (lookup_hit),
        .lookup_way   (lookup_way),
        .victim_ack   (victim_ack),
        .ready        (ready),
        .victim_valid (victim_valid),
        .victim_way   (victim_way)
    );

    function automatic int ref_victim(input logic [W-2:0] s);
        int n = 0;
        int lo = 0;
        int span = W;
        while (span > 1) begin
            span = span / 2;
            if (s[n]) begin
                lo = lo + span;
                n = 2 * n + 2;
            end else begin
                n = 2 * n + 1;
            end
        end
        return lo;
    endfunction

    function automatic logic [W-2:0] ref_touch(input logic [W-2:0] s, input int w);
        logic [W-2:0] r = s;
        int n = 0;
        int lo = 0;
        int span = W;
        while (span > 1) begin
            span = span / 2;
            if (w >= lo + span) begin
                r[n] = 1'b0;
                lo = lo + span;
                n = 2 * n + 2;
            end else begin
                r[n] = 1'b1;
                n = 2 * n + 1;
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_apply(input bit v, input int s, input bit h, input int w, input bit ack);
        bit captured = 1'b0;
        if (v) begin
            if (h) begin
                mdl[s] = ref_touch(mdl[s], w);
            end else if (!held_v || ack) begin
                held_w = ref_victim(mdl[s]);
                mdl[s] = ref_touch(mdl[s], held_w);
                held_v = 1'b1;
                captured = 1'b1;
            end
        end
        if (ack && !captured) held_v = 1'b0;
    endtask

    task automatic compare_outputs(input string req);
        chk(victim_valid == held_v, req, int'(victim_valid), int'(held_v));
        if (held_v) chk(int'(victim_way) == held_w, req, int'(victim_way), held_w);
    endtask

    // One lookup (optional) plus optional acknowledge in its handling cycle.
    task automatic step(input bit v, input int s, input bit h, input int w, input bit ack,
                        input string req);
        @(negedge clk);
        lookup_valid = v;
        lookup_set   = SB'(s);
        lookup_hit   = h;
        lookup_way   = WB'(w);
        @(negedge clk);
        lookup_valid = 1'b0;
        victim_ack   = ack;
        model_apply(v, s, h, w, ack);
        @(negedge clk);
        victim_ack = 1'b0;
        compare_outputs(req);
    endtask

    task automatic t_reset_init();
        int cnt = 0;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk(victim_valid == 1'b0, "R1 reset victim_valid", int'(victim_valid), 0);
        rst = 1'b0;
        chk(ready == 1'b0, "R1 ready low at reset release", int'(ready), 0);
        // Miss on set 1 held during the whole sweep: must be ignored (R2).
        lookup_valid = 1'b1;
        lookup_set   = SB'(1);
        lookup_hit   = 1'b0;
        while (!ready && cnt < 50) begin
            @(negedge clk);
            cnt++;
            if (!ready) chk(victim_valid == 1'b0, "R1 no victim while init", int'(victim_valid), 0);
        end
        lookup_valid = 1'b0;
        chk(cnt == N, "R1 init length", cnt, N);
        repeat (2) @(negedge clk);
        chk(victim_valid == 1'b0, "R2 lookup during init ignored", int'(victim_valid), 0);
        chk(ready == 1'b1, "R1 ready stays high", int'(ready), 1);
    endtask

    task automatic t_fresh_and_sweep();
        int order [5] = '{0, 2, 1, 3, 0};
        step(1'b1, 0, 1'b0, 0, 1'b0, "R3 fresh miss");
        chk(int'(victim_way) == 0, "R3 fresh set picks way 0", int'(victim_way), 0);
        for (int k = 1; k < 5; k++) begin
            step(1'b1, 0, 1'b0, 0, 1'b1, "R4 acked miss sequence");
            chk(int'(victim_way) == order[k], "R4 literal order", int'(victim_way), order[k]);
        end
        step(1'b0, 0, 1'b0, 0, 1'b1, "R7 ack clears");
        chk(victim_valid == 1'b0, "R7 ack clears valid", int'(victim_valid), 0);
        step(1'b0, 0, 1'b0, 0, 1'b1, "R7 idle ack no effect");
        chk(victim_valid == 1'b0, "R7 idle ack keeps invalid", int'(victim_valid), 0);
    endtask

    task automatic t_hit_mru();
        step(1'b1, 2, 1'b1, 0, 1'b0, "R5 hit way 0");
        chk(victim_valid == 1'b0, "R5 hit captures nothing", int'(victim_valid), 0);
        step(1'b1, 2, 1'b0, 0, 1'b0, "R5 miss after hit");
        chk(int'(victim_way) == 2, "R5 hit way 0 then miss picks 2 (R10 set 2 untouched by set 0)",
            int'(victim_way), 2);
    endtask

    task automatic t_hold_and_pending();
        logic [WB-1:0] w0;
        w0 = victim_way;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 3, 1'b1, k, 1'b0, "R6 hits while held");
            chk(victim_valid && victim_way == w0, "R6 victim held across hits",
                int'(victim_way), int'(w0));
        end
        step(1'b1, 1, 1'b0, 0, 1'b0, "R8 miss while pending");
        chk(victim_way == w0, "R8 held victim unchanged", int'(victim_way), int'(w0));
        step(1'b0, 0, 1'b0, 0, 1'b1, "R7 release");
        step(1'b1, 1, 1'b0, 0, 1'b0, "R8 dropped miss left set 1 fresh");
        chk(int'(victim_way) == 0, "R8 set 1 tree untouched", int'(victim_way), 0);
    endtask

    task automatic t_ack_same_cycle();
        int exp_w;
        exp_w = ref_victim(mdl[3]);
        step(1'b1, 3, 1'b0, 0, 1'b1, "R9 miss with ack");
        chk(victim_valid == 1'b1, "R9 valid stays high", int'(victim_valid), 1);
        chk(int'(victim_way) == exp_w, "R9 new victim captured", int'(victim_way), exp_w);
    endtask

    task automatic t_back_to_back();
        step(1'b0, 0, 1'b0, 0, 1'b1, "R11 release");
        @(negedge clk);
        lookup_valid = 1'b1; lookup_set = SB'(0); lookup_hit = 1'b1; lookup_way = WB'(1);
        @(negedge clk);
        lookup_way = WB'(3);
        model_apply(1'b1, 0, 1'b1, 1, 1'b0);
        @(negedge clk);
        lookup_hit = 1'b0;
        model_apply(1'b1, 0, 1'b1, 3, 1'b0);
        @(negedge clk);
        lookup_valid = 1'b0;
        model_apply(1'b1, 0, 1'b0, 0, 1'b0);
        @(negedge clk);
        compare_outputs("R11 consecutive same-set lookups");
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], int'(lfsr[2:1]), lfsr[3] & lfsr[9], int'(lfsr[8:7]),
                 lfsr[4] & ~lfsr[11], "R12 random vs model");
        end
    endtask

    initial begin
        t_reset_init();
        t_fresh_and_sweep();
        t_hit_mru();
        t_hold_and_pending();
        t_ack_same_cycle();
        t_back_to_back();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule